// File: doc/BRIEF.md
# 1-Wire ROM Command Selector

This block is the addressing layer of a 1-Wire slave. A separate slot-timing engine turns line activity into single-cycle events: a long bus reset, a short bus reset, a write slot carrying one received bit, and a read slot in which the slave may pull the line low. The selector asks for a presence pulse after every bus reset, collects the eight-bit ROM command and carries out the requested addressing function against a 64-bit registration number. That number is assembled from a 56-bit serial input and an 8-bit check code that the block computes itself.

Once the addressing sequence succeeds, `selected` rises and stays high until the next bus reset. From that point the memory-function layer owns the bus. If the device loses a match or a search, or receives a command it does not know, it stays silent and ignores all slots until the next bus reset. The block also keeps the overdrive-speed flag that the slot engine uses to pick its timing.

Top module: `owrom_selector`

## Requirements
- R1: After `rst_n` is released, `selected`, `overdrive`, `presence_req` and `tx_drive` are 0, and write and read slots have no effect until the first bus reset.
- R2: Every long or short bus reset raises `presence_req` for exactly the one cycle after the event, clears `selected`, and restarts command reception, discarding any partially received command bits.
- R3: A long bus reset clears `overdrive`; a short bus reset leaves it unchanged.
- R4: The command byte is received least significant bit first. Code CCh selects the device as soon as its eighth bit arrives. Any code other than 33h, 55h, F0h, CCh, 3Ch, 69h and ECh deselects the device: it never drives and never becomes selected until the next bus reset.
- R5: After 33h, the next 64 read slots return registration bits 0 to 63 in that order, with the device driving each one. The device is selected after the 64th bit.
- R6: Registration bits 55:0 equal `serial_no`. Bits 63:56 hold a CRC-8 over those 56 bits, taken least significant bit first from a zero start with polynomial x^8+x^5+x^4+1. For serial 00000001B81C02h the code is A2h.
- R7: After 55h or 69h, each of the next 64 written bits is compared with the registration bit of the same index. If all 64 agree, the device is selected. On the first disagreement the device deselects and ignores the remaining bits.
- R8: After F0h, each registration bit, starting with bit 0, takes a triplet. The device first drives the bit on a read slot, then drives its complement on a second read slot, then receives the master's choice on a write slot. A choice that differs from the bit deselects the device. Agreement on all 64 selects it.
- R9: ECh acts like F0h only when `alarm_flags & search_mask` is non-zero at the eighth command bit (bit 2 low-temperature, bit 1 high-temperature, bit 0 timer alarm). Otherwise the device deselects.
- R10: Codes 3Ch and 69h set `overdrive` at the edge of their eighth bit. `overdrive` then stays set, even after a failed match, until a long bus reset.
- R11: `tx_drive` is 1 only during read-ROM bits and the bit and complement steps of a search. Whenever `tx_drive` is 0, `tx_bit` is 1, which is the value a released line reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rst_long | input | 1 | Pulse: bus reset of standard length seen |
| bus_rst_short | input | 1 | Pulse: short (overdrive-length) bus reset seen |
| wr_slot | input | 1 | Pulse: master write slot completed |
| wr_bit | input | 1 | Bit carried by the write slot |
| rd_slot | input | 1 | Pulse: master read slot; consumes the offered bit |
| serial_no | input | 56 | Family code and serial, bit 0 sent first |
| alarm_flags | input | 3 | Alarm flags: low temp, high temp, timer |
| search_mask | input | 3 | Per-flag enables for conditional search |
| presence_req | output | 1 | Request to emit a presence pulse |
| tx_drive | output | 1 | Device takes part in the next read slot |
| tx_bit | output | 1 | Bit offered for the next read slot |
| overdrive | output | 1 | Overdrive speed flag |
| selected | output | 1 | Addressing complete; memory layer may proceed |

## Verification
A bus reset, write slot or read slot is taken at one rising edge. `presence_req`, `selected` and `overdrive` show the result from the next cycle on, so the bench drives each event for one full cycle starting at a falling edge and samples these outputs at the following falling edge. `tx_drive` and `tx_bit` are derived without a register from the state left by earlier events, so the bench reads them at the falling edge on which it raises `rd_slot`, before that slot advances the state. A mismatch or rejected command is confirmed by later read slots that are not driven and by `selected` staying low.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

  localparam int CMD_W = 8;
  localparam int CRC_W = 8;
  // reflected form of x^8 + x^5 + x^4 + 1
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

  typedef enum logic [2:0] {
    ST_HALT,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH,
    ST_SEL,
    ST_DESEL
  } rom_state_t;

  typedef enum logic [1:0] {
    PH_TRUE,
    PH_COMP,
    PH_PICK
  } srch_phase_t;

  localparam logic [CMD_W-1:0] OP_READ     = 8'h33;
  localparam logic [CMD_W-1:0] OP_MATCH    = 8'h55;
  localparam logic [CMD_W-1:0] OP_SEARCH   = 8'hF0;
  localparam logic [CMD_W-1:0] OP_SKIP     = 8'hCC;
  localparam logic [CMD_W-1:0] OP_OD_SKIP  = 8'h3C;
  localparam logic [CMD_W-1:0] OP_OD_MATCH = 8'h69;
  localparam logic [CMD_W-1:0] OP_COND     = 8'hEC;

  // one shift of the check-code register, data bit entering at the low end
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                 input logic d);
    logic fb;
    fb = c[0] ^ d;
    crc_step = (c >> 1) ^ (fb ? CRC_POLY_REFL : '0);
  endfunction

endpackage

// File: rtl/owrom_regnum.sv
module owrom_regnum
  import owrom_pkg::*;
#(
  parameter int SERIAL_W = 56
) (
  input  logic [SERIAL_W-1:0]       serial,
  output logic [SERIAL_W+CRC_W-1:0] regnum
);
  logic [CRC_W-1:0] crc;

  always_comb begin
    crc = '0;
    for (int k = 0; k < SERIAL_W; k++) begin
      crc = crc_step(crc, serial[k]);
    end
  end

  assign regnum = {crc, serial};
endmodule

// File: rtl/owrom_cmd_shift.sv
module owrom_cmd_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic         full,
  output logic [W-1:0] value
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;

  assign value = {din, sr[W-1:1]};
  assign full  = shift_en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clr) begin
      sr  <= '0;
      cnt <= '0;
    end else if (shift_en) begin
      sr  <= value;
      cnt <= full ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/owrom_bit_ctr.sv
module owrom_bit_ctr #(
  parameter int N = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 inc,
  output logic [$clog2(N)-1:0] idx,
  output logic                 at_last
);
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  assign at_last = (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (clr)     idx <= '0;
    else if (inc)     idx <= idx + 1'b1;
  end
endmodule

// File: rtl/owrom_selector.sv
module owrom_selector
  import owrom_pkg::*;
#(
  parameter int SERIAL_W = 56,
  parameter int COND_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_rst_long,
  input  logic                bus_rst_short,
  input  logic                wr_slot,
  input  logic                wr_bit,
  input  logic                rd_slot,
  input  logic [SERIAL_W-1:0] serial_no,
  input  logic [COND_W-1:0]   alarm_flags,
  input  logic [COND_W-1:0]   search_mask,
  output logic                presence_req,
  output logic                tx_drive,
  output logic                tx_bit,
  output logic                overdrive,
  output logic                selected
);
  localparam int ID_W = SERIAL_W + CRC_W;
  localparam int IW   = $clog2(ID_W);

  rom_state_t  state, state_n;
  srch_phase_t phase, phase_n;
  logic        od_q, od_n;
  logic        pres_q;

  logic [ID_W-1:0]  regnum;
  logic [IW-1:0]    idx;
  logic             at_last;
  logic [CMD_W-1:0] cmd_val;

  // named events, also used by the checker
  logic bus_rst;
  logic cmd_done;
  logic bit_step;
  logic seq_end;
  logic mismatch;
  logic cur_bit;
  logic cond_hit;
  logic shift_en;
  logic ctr_inc;

  assign bus_rst  = bus_rst_long | bus_rst_short;
  assign cur_bit  = regnum[idx];
  assign cond_hit = |(alarm_flags & search_mask);
  assign shift_en = (state == ST_CMD) && wr_slot && !bus_rst;
  assign mismatch = wr_slot && (wr_bit != cur_bit);

  owrom_regnum #(.SERIAL_W(SERIAL_W)) u_regnum (
    .serial (serial_no),
    .regnum (regnum)
  );

  owrom_cmd_shift #(.W(CMD_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (bus_rst),
    .shift_en (shift_en),
    .din      (wr_bit),
    .full     (cmd_done),
    .value    (cmd_val)
  );

  owrom_bit_ctr #(.N(ID_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (bus_rst),
    .inc     (ctr_inc),
    .idx     (idx),
    .at_last (at_last)
  );

  assign ctr_inc = bit_step && !at_last;
  assign seq_end = bit_step && at_last;

  always_comb begin
    state_n  = state;
    phase_n  = phase;
    od_n     = od_q;
    bit_step = 1'b0;
    if (bus_rst) begin
      state_n = ST_CMD;
      phase_n = PH_TRUE;
      if (bus_rst_long) od_n = 1'b0;
    end else begin
      case (state)
        ST_CMD: begin
          if (cmd_done) begin
            case (cmd_val)
              OP_READ:     state_n = ST_READ;
              OP_MATCH:    state_n = ST_MATCH;
              OP_OD_MATCH: begin
                state_n = ST_MATCH;
                od_n    = 1'b1;
              end
              OP_SKIP:     state_n = ST_SEL;
              OP_OD_SKIP:  begin
                state_n = ST_SEL;
                od_n    = 1'b1;
              end
              OP_SEARCH:   state_n = ST_SRCH;
              OP_COND:     state_n = cond_hit ? ST_SRCH : ST_DESEL;
              default:     state_n = ST_DESEL;
            endcase
          end
        end
        ST_READ: begin
          if (rd_slot) begin
            bit_step = 1'b1;
            if (at_last) state_n = ST_SEL;
          end
        end
        ST_MATCH: begin
          if (wr_slot) begin
            if (mismatch) begin
              state_n = ST_DESEL;
            end else begin
              bit_step = 1'b1;
              if (at_last) state_n = ST_SEL;
            end
          end
        end
        ST_SRCH: begin
          case (phase)
            PH_TRUE: if (rd_slot) phase_n = PH_COMP;
            PH_COMP: if (rd_slot) phase_n = PH_PICK;
            PH_PICK: begin
              if (wr_slot) begin
                if (mismatch) begin
                  state_n = ST_DESEL;
                end else begin
                  phase_n  = PH_TRUE;
                  bit_step = 1'b1;
                  if (at_last) state_n = ST_SEL;
                end
              end
            end
            default: phase_n = PH_TRUE;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_HALT;
      phase  <= PH_TRUE;
      od_q   <= 1'b0;
      pres_q <= 1'b0;
    end else begin
      state  <= state_n;
      phase  <= phase_n;
      od_q   <= od_n;
      pres_q <= bus_rst;
    end
  end

  always_comb begin
    tx_drive = 1'b0;
    tx_bit   = 1'b1;
    if (state == ST_READ) begin
      tx_drive = 1'b1;
      tx_bit   = cur_bit;
    end else if (state == ST_SRCH && phase == PH_TRUE) begin
      tx_drive = 1'b1;
      tx_bit   = cur_bit;
    end else if (state == ST_SRCH && phase == PH_COMP) begin
      tx_drive = 1'b1;
      tx_bit   = ~cur_bit;
    end
  end

  assign presence_req = pres_q;
  assign overdrive    = od_q;
  assign selected     = (state == ST_SEL);
endmodule

// File: rtl/owrom_selector_chk.sv
module owrom_selector_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_rst_long,
  input logic bus_rst_short,
  input logic presence_req,
  input logic overdrive,
  input logic selected,
  input logic tx_drive,
  input logic cmd_done,
  input logic seq_end
);
  p_presence_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_long || bus_rst_short) |=> presence_req);

  p_presence_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (presence_req && !bus_rst_long && !bus_rst_short) |=> !presence_req);

  p_reset_drops_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_long || bus_rst_short) |=> !selected);

  p_long_clears_od_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_long |=> !overdrive);

  p_short_keeps_od_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_short && !bus_rst_long) |=> (overdrive == $past(overdrive)));

  p_od_from_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overdrive) |-> $past(cmd_done));

  p_od_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (overdrive && !bus_rst_long) |=> overdrive);

  p_sel_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> ($past(cmd_done) || $past(seq_end)));

  p_silent_when_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> !tx_drive);
endmodule

bind owrom_selector owrom_selector_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_rst_long  (bus_rst_long),
  .bus_rst_short (bus_rst_short),
  .presence_req  (presence_req),
  .overdrive     (overdrive),
  .selected      (selected),
  .tx_drive      (tx_drive),
  .cmd_done      (cmd_done),
  .seq_end       (seq_end)
);

// File: tb/tb_owrom_selector.sv
module tb_owrom_selector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst_long = 1'b0;
  logic        bus_rst_short = 1'b0;
  logic        wr_slot = 1'b0;
  logic        wr_bit = 1'b0;
  logic        rd_slot = 1'b0;
  logic [55:0] serial_no = '0;
  logic [2:0]  alarm_flags = '0;
  logic [2:0]  search_mask = '0;
  logic        presence_req, tx_drive, tx_bit, overdrive, selected;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  localparam logic [55:0] SER_A = 56'h00000001B81C02;
  localparam logic [55:0] SER_B = 56'h3C5A96E1D24B28;

  // {cmd, flags, mask, exp_selected, exp_overdrive, exp_drive}
  localparam logic [16:0] VEC [0:11] = '{
    {8'hCC, 3'b000, 3'b000, 1'b1, 1'b0, 1'b0},
    {8'h3C, 3'b000, 3'b000, 1'b1, 1'b1, 1'b0},
    {8'h33, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1},
    {8'h55, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0},
    {8'h69, 3'b000, 3'b000, 1'b0, 1'b1, 1'b0},
    {8'hF0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1},
    {8'hEC, 3'b100, 3'b100, 1'b0, 1'b0, 1'b1},
    {8'hEC, 3'b010, 3'b101, 1'b0, 1'b0, 1'b0},
    {8'hEC, 3'b001, 3'b001, 1'b0, 1'b0, 1'b1},
    {8'hEC, 3'b011, 3'b010, 1'b0, 1'b0, 1'b1},
    {8'hA5, 3'b111, 3'b111, 1'b0, 1'b0, 1'b0},
    {8'h00, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0}
  };

  owrom_selector dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rst_long  (bus_rst_long),
    .bus_rst_short (bus_rst_short),
    .wr_slot       (wr_slot),
    .wr_bit        (wr_bit),
    .rd_slot       (rd_slot),
    .serial_no     (serial_no),
    .alarm_flags   (alarm_flags),
    .search_mask   (search_mask),
    .presence_req  (presence_req),
    .tx_drive      (tx_drive),
    .tx_bit        (tx_bit),
    .overdrive     (overdrive),
    .selected      (selected)
  );

  always #10 clk = ~clk;

  // stage-by-stage form of x^8+x^5+x^4+1, bits taken low first
  function automatic logic [7:0] ref_crc(input logic [55:0] s);
    logic [7:0] r;
    logic fb;
    r = 8'h00;
    for (int k = 0; k < 56; k++) begin
      fb = r[0] ^ s[k];
      r  = {fb, r[7:5], r[4] ^ fb, r[3] ^ fb, r[2:1]};
    end
    return r;
  endfunction

  function automatic logic [63:0] ref_id(input logic [55:0] s);
    return {ref_crc(s), s};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_reset(input bit is_long);
    bus_rst_long  = is_long;
    bus_rst_short = !is_long;
    @(negedge clk);
    bus_rst_long  = 1'b0;
    bus_rst_short = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    wr_slot = 1'b1;
    wr_bit  = b;
    @(negedge clk);
    wr_slot = 1'b0;
    wr_bit  = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic read_slot(output logic d, output logic b);
    d = tx_drive;
    b = tx_bit;
    rd_slot = 1'b1;
    @(negedge clk);
    rd_slot = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic d, b;
    logic [63:0] id, got;
    serial_no = SER_A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and no response before a bus reset
    chk("R1 selected", selected, 0);
    chk("R1 overdrive", overdrive, 0);
    chk("R1 presence", presence_req, 0);
    chk("R1 drive", tx_drive, 0);
    send_byte(8'hCC);
    chk("R1 skip ignored before bus reset", selected, 0);
    read_slot(d, b);
    chk("R1 no drive before bus reset", d, 0);

    // R2: presence pulse timing
    bus_reset(1'b1);
    chk("R2 presence after reset", presence_req, 1);
    @(negedge clk);
    chk("R2 presence one cycle", presence_req, 0);

    // R4/R9/R10/R11: command table
    for (int v = 0; v < 12; v++) begin
      alarm_flags = VEC[v][8:6];
      search_mask = VEC[v][5:3];
      bus_reset(1'b1);
      send_byte(VEC[v][16:9]);
      chk("R4 selected after command", selected, VEC[v][2]);
      chk("R10 overdrive after command", overdrive, VEC[v][1]);
      chk("R9 R11 drive after command", tx_drive, VEC[v][0]);
      if (!VEC[v][0]) chk("R11 released bit reads 1", tx_bit, 1);
    end
    alarm_flags = '0;
    search_mask = '0;

    // R4: unknown command stays silent even after more traffic
    bus_reset(1'b1);
    send_byte(8'hA5);
    send_byte(8'hCC);
    read_slot(d, b);
    chk("R4 unknown command stays deselected", {d, selected}, 2'b00);

    // R2: short reset discards partial command
    bus_reset(1'b1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_reset(1'b0);
    chk("R2 selected cleared", selected, 0);
    send_byte(8'hCC);
    chk("R2 restart after short reset", selected, 1);
    bus_reset(1'b0);
    chk("R2 reset drops selection", selected, 0);

    // R5/R6: read rom
    chk("R6 reference code", ref_crc(SER_A), 8'hA2);
    bus_reset(1'b1);
    send_byte(8'h33);
    got = '0;
    for (int i = 0; i < 64; i++) begin
      read_slot(d, b);
      got[i] = b;
      if (!d) chk("R5 driven read rom bit", d, 1);
      if (i < 63) chk("R5 not selected mid read", selected, 0);
    end
    chk("R6 registration number", got, {8'hA2, SER_A});
    chk("R5 selected after 64 bits", selected, 1);

    // R7: match with correct id
    serial_no = SER_B;
    id = ref_id(SER_B);
    bus_reset(1'b1);
    send_byte(8'h55);
    for (int i = 0; i < 64; i++) send_bit(id[i]);
    chk("R7 match selects", selected, 1);
    chk("R7 plain match keeps speed", overdrive, 0);

    // R7/R10: overdrive match with a wrong bit
    bus_reset(1'b1);
    send_byte(8'h69);
    chk("R10 overdrive set by od match", overdrive, 1);
    for (int i = 0; i < 64; i++) send_bit(i == 5 ? ~id[i] : id[i]);
    chk("R7 mismatch deselects", selected, 0);
    read_slot(d, b);
    chk("R7 silent after mismatch", d, 0);
    chk("R10 overdrive survives failed match", overdrive, 1);

    // R3: short reset keeps, long reset clears
    bus_reset(1'b0);
    chk("R3 short keeps overdrive", overdrive, 1);
    bus_reset(1'b1);
    chk("R3 long clears overdrive", overdrive, 0);

    // R8: full search
    bus_reset(1'b1);
    send_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      logic d2, b2;
      read_slot(d, b);
      read_slot(d2, b2);
      if ({d, b, d2, b2} !== {1'b1, id[i], 1'b1, ~id[i]})
        chk("R8 search triplet", {d, b, d2, b2}, {1'b1, id[i], 1'b1, ~id[i]});
      send_bit(id[i]);
    end
    checks++;
    chk("R8 search selects", selected, 1);

    // R8: search loses at bit 3
    bus_reset(1'b1);
    send_byte(8'hF0);
    for (int i = 0; i < 4; i++) begin
      read_slot(d, b);
      read_slot(d, b);
      send_bit(i == 3 ? ~id[i] : id[i]);
    end
    read_slot(d, b);
    chk("R8 silent after lost search", {d, b}, 2'b01);
    for (int i = 4; i < 64; i++) send_bit(id[i]);
    chk("R8 lost search never selects", selected, 0);

    // R9: conditional search runs to selection when enabled
    alarm_flags = 3'b010;
    search_mask = 3'b010;
    bus_reset(1'b1);
    send_byte(8'hEC);
    for (int i = 0; i < 64; i++) begin
      read_slot(d, b);
      read_slot(d, b);
      send_bit(id[i]);
    end
    chk("R9 conditional search selects", selected, 1);

    finish_run();
  end
endmodule